// File: doc/BRIEF.md
# Indirect Add-With-Carry Execution Unit

This unit executes a family of eight 13-bit instructions that add a 4-bit word from data memory, plus the carry flag, into one of two 4-bit accumulators. The memory word is located through one of two 16-bit index registers. Some forms advance the index register by one after the read. A separate prefix operation can load an 8-bit immediate. When a prefix is pending, the plain (non-incrementing) forms read from a fixed page instead of the index register. With the low index the page is 0x00xx. With the high index it is 0xFFxx.

The unit sits inside a narrow-data controller core and accepts one instruction per cycle. In the issue cycle it presents the read address to a synchronous data memory. The memory returns the word one cycle later. In that cycle the sum is written back together with the carry and zero flags. The index-register increment lands at the end of the issue cycle, so a following instruction already sees the new pointer. A following instruction also sees the previous accumulator and carry results without any stall.

Top module: `adc_ind_unit`

## Requirements
- R1: After synchronous reset both accumulators, both index registers and the C, Z and E flags are 0, and no memory read is requested.
- R2: An accepted instruction is one whose bits [12:3] equal 10'b1100111100, so its value lies in 0x19E0..0x19E7. Any other word presented with `insn_valid` issues no memory read and changes no accumulator, index register, C or Z.
- R3: The instruction field decoding is as follows. Bit 2 picks the accumulator: 1 for B, 0 for A. Bit 1 picks the index register: 1 for Y, 0 for X. The picked accumulator becomes its old value + memory word + C, modulo 16. The other accumulator is unchanged.
- R4: C becomes the carry out of bit 3 of that addition. Z becomes 1 exactly when the 4-bit result is 0. Both are updated in the same cycle as the accumulator.
- R5: `mem_rd` is high during the issue cycle, and `mem_addr` in that cycle is the picked index register, unless R7 or R8 applies.
- R6: When bit 0 is 1, the read uses the pre-increment pointer and the picked index register is incremented at the end of the issue cycle. It wraps from 0xFFFF to 0x0000. The increment never alters C or Z.
- R7: When E is set and a non-incrementing X form issues, the read address is {8'h00, imm} and X is unchanged.
- R8: When E is set and a non-incrementing Y form issues, the read address is {8'hFF, imm} and Y is unchanged.
- R9: Incrementing forms ignore a pending prefix. They read at the index register and increment it as in R6.
- R10: A `pfx_load` pulse sets E and captures `pfx_imm`. Any `insn_valid` cycle without `pfx_load` clears E, whatever the opcode. If both are high in one cycle, the prefix is taken and the instruction is dropped with no memory read.
- R11: Instructions issued on consecutive cycles behave exactly like the same instructions issued one at a time, including carry chaining and pointer advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word present this cycle |
| insn | input | 13 | Instruction word |
| pfx_load | input | 1 | Prefix operation this cycle |
| pfx_imm | input | 8 | Prefix immediate |
| mem_rd | output | 1 | Data-memory read request |
| mem_addr | output | 16 | Data-memory read address |
| mem_rdata | input | 4 | Read data, valid the cycle after `mem_rd` |
| acc_a | output | 4 | Accumulator A |
| acc_b | output | 4 | Accumulator B |
| idx_x | output | 16 | Index register X |
| idx_y | output | 16 | Index register Y |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_e | output | 1 | Prefix-pending flag |

## Verification
The bench sweeps every opcode with and without a pending prefix. Because the memory contents are address-dependent, a page mix-up shows up as the wrong sum. A design that honoured the prefix on incrementing forms, or that put the low index on page 0xFF, would read the wrong word. The bench drives the low index all the way to 0xFFFF and steps it once more: a pointer that does not wrap, or one that updates the flags, is caught there. A back-to-back burst exposes a write-back or increment that lands a cycle late and breaks carry chaining. The bench also checks out-of-family words and collisions between the prefix and an instruction. These cases catch a design that leaves E set or that executes a dropped instruction.

// File: rtl/adc_pkg.sv
package adc_pkg;

    localparam int DATA_W = 4;
    localparam int ADDR_W = 16;
    localparam int INSN_W = 13;
    localparam int EXT_W  = 8;
    localparam int SEL_W  = 3;
    localparam logic [INSN_W-SEL_W-1:0] FAMILY = 10'h33C;

    typedef struct packed {
        logic sel_b;
        logic sel_y;
        logic post_inc;
    } op_t;

    typedef struct packed {
        logic              valid;
        logic              sel_b;
    } wb_t;

    function automatic logic [ADDR_W-1:0] page_addr(input logic sel_y,
                                                    input logic [EXT_W-1:0] imm);
        return {{(ADDR_W-EXT_W){sel_y}}, imm};
    endfunction

endpackage

// File: rtl/adc_decode.sv
module adc_decode
    import adc_pkg::*;
#(
    parameter int IW = INSN_W,
    parameter int SW = SEL_W,
    parameter logic [IW-SW-1:0] FAM = FAMILY
) (
    input  logic          insn_valid,
    input  logic          pfx_load,
    input  logic [IW-1:0] insn,
    output logic          issue,
    output op_t           op
);
    logic match;

    always_comb begin
        match       = (insn[IW-1:SW] == FAM);
        issue       = insn_valid && !pfx_load && match;
        op.sel_b    = insn[2];
        op.sel_y    = insn[1];
        op.post_inc = insn[0];
    end
endmodule

// File: rtl/adc_agen.sv
module adc_agen
    import adc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int EW = EXT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue,
    input  op_t           op,
    input  logic          ext_pend,
    input  logic [EW-1:0] ext_imm,
    input  logic [AW-1:0] idx_x,
    input  logic [AW-1:0] idx_y,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] idx_inc
);
    logic [AW-1:0] base;

    always_comb begin
        base    = op.sel_y ? idx_y : idx_x;
        idx_inc = base + AW'(1);
        if (ext_pend && !op.post_inc)
            ea = {{(AW-EW){op.sel_y}}, ext_imm};
        else
            ea = base;
    end

    p_addr_r5: assert property (@(posedge clk) disable iff (rst)
        (issue && !ext_pend) |-> ea == (op.sel_y ? idx_y : idx_x));
    p_page_x_r7: assert property (@(posedge clk) disable iff (rst)
        (issue && ext_pend && !op.post_inc && !op.sel_y) |-> ea[AW-1:EW] == '0);
    p_page_y_r8: assert property (@(posedge clk) disable iff (rst)
        (issue && ext_pend && !op.post_inc && op.sel_y) |-> ea[AW-1:EW] == '1);
    p_inc_noext_r9: assert property (@(posedge clk) disable iff (rst)
        (issue && op.post_inc) |-> ea == (op.sel_y ? idx_y : idx_x));
endmodule

// File: rtl/adc_alu.sv
module adc_alu
    import adc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          zero
);
    logic [DW:0] full;

    always_comb begin
        full = {1'b0, opa} + {1'b0, opb} + {{DW{1'b0}}, cin};
        sum  = full[DW-1:0];
        cout = full[DW];
        zero = (full[DW-1:0] == '0);
    end

    always_comb begin
        a_sum_r4: assert ((sum == '0) == zero);
    end
endmodule

// File: rtl/adc_ind_unit.sv
module adc_ind_unit
    import adc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int IW = INSN_W,
    parameter int EW = EXT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          insn_valid,
    input  logic [IW-1:0] insn,
    input  logic          pfx_load,
    input  logic [EW-1:0] pfx_imm,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] acc_a,
    output logic [DW-1:0] acc_b,
    output logic [AW-1:0] idx_x,
    output logic [AW-1:0] idx_y,
    output logic          flag_c,
    output logic          flag_z,
    output logic          flag_e
);
    localparam int NREG = 2;

    logic          issue;
    op_t           op;
    logic [AW-1:0] ea, idx_inc;
    logic [EW-1:0] imm_q;
    logic          e_q, c_q, z_q;
    wb_t           wb_q;
    logic [DW-1:0] acc_q [NREG];
    logic [AW-1:0] idx_q [NREG];
    logic [DW-1:0] sum;
    logic          cout, zero;

    adc_decode #(.IW(IW)) u_dec (
        .insn_valid(insn_valid), .pfx_load(pfx_load), .insn(insn),
        .issue(issue), .op(op)
    );

    adc_agen #(.AW(AW), .EW(EW)) u_agen (
        .clk(clk), .rst(rst), .issue(issue), .op(op),
        .ext_pend(e_q), .ext_imm(imm_q),
        .idx_x(idx_q[0]), .idx_y(idx_q[1]),
        .ea(ea), .idx_inc(idx_inc)
    );

    adc_alu #(.DW(DW)) u_alu (
        .opa(acc_q[wb_q.sel_b]), .opb(mem_rdata), .cin(c_q),
        .sum(sum), .cout(cout), .zero(zero)
    );

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    acc_q[g] <= '0;
                    idx_q[g] <= '0;
                end else begin
                    if (wb_q.valid && (wb_q.sel_b == 1'(g)))
                        acc_q[g] <= sum;
                    if (issue && op.post_inc && (op.sel_y == 1'(g)))
                        idx_q[g] <= idx_inc;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            e_q   <= 1'b0;
            imm_q <= '0;
            c_q   <= 1'b0;
            z_q   <= 1'b0;
            wb_q  <= '0;
        end else begin
            if (pfx_load) begin
                e_q   <= 1'b1;
                imm_q <= pfx_imm;
            end else if (insn_valid) begin
                e_q   <= 1'b0;
            end
            wb_q.valid <= issue;
            wb_q.sel_b <= op.sel_b;
            if (wb_q.valid) begin
                c_q <= cout;
                z_q <= zero;
            end
        end
    end

    assign mem_rd   = issue;
    assign mem_addr = ea;
    assign acc_a    = acc_q[0];
    assign acc_b    = acc_q[1];
    assign idx_x    = idx_q[0];
    assign idx_y    = idx_q[1];
    assign flag_c   = c_q;
    assign flag_z   = z_q;
    assign flag_e   = e_q;

    p_foreign_r2: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && insn[IW-1:SEL_W] != FAMILY) |-> !mem_rd);
    p_zero_r4: assert property (@(posedge clk) disable iff (rst)
        wb_q.valid |=> flag_z == ($past(wb_q.sel_b) ? (acc_b == '0) : (acc_a == '0)));
    p_incr_x_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && insn[0] && !insn[1]) |=> idx_x == $past(idx_x) + AW'(1));
    p_flags_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !wb_q.valid |=> ($stable(flag_c) && $stable(flag_z)));
    p_eclear_r10: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && !pfx_load) |=> !flag_e);
    p_collide_r10: assert property (@(posedge clk) disable iff (rst)
        pfx_load |-> !mem_rd);
endmodule

// File: tb/adc_ind_unit_tb.sv
module adc_ind_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_valid = 1'b0;
    logic [12:0] insn = '0;
    logic        pfx_load = 1'b0;
    logic [7:0]  pfx_imm = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [3:0]  mem_rdata = '0;
    logic [3:0]  acc_a, acc_b;
    logic [15:0] idx_x, idx_y;
    logic        flag_c, flag_z, flag_e;

    int n_run = 0, n_fail = 0;

    logic [3:0]  m_a = 0, m_b = 0;
    logic [15:0] m_x = 0, m_y = 0;
    logic        m_c = 0, m_z = 0, m_e = 0;
    logic [7:0]  m_imm = 0;

    always #10 clk = ~clk;

    adc_ind_unit u_dut (
        .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn(insn),
        .pfx_load(pfx_load), .pfx_imm(pfx_imm), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .acc_a(acc_a),
        .acc_b(acc_b), .idx_x(idx_x), .idx_y(idx_y), .flag_c(flag_c),
        .flag_z(flag_z), .flag_e(flag_e)
    );

    function automatic logic [3:0] mval(input logic [15:0] a);
        int v;
        v = int'(a[3:0]) + 3 * int'(a[7:4]) + 5 * int'(a[11:8]) + 7 * int'(a[15:12]) + 1;
        return v[3:0];
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= mval(mem_addr);

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk(acc_a == m_a, {tag, " acc_a"}, 16'(acc_a), 16'(m_a));
        chk(acc_b == m_b, {tag, " acc_b"}, 16'(acc_b), 16'(m_b));
        chk(idx_x == m_x, {tag, " idx_x"}, idx_x, m_x);
        chk(idx_y == m_y, {tag, " idx_y"}, idx_y, m_y);
        chk(flag_c == m_c, {tag, " flag_c"}, 16'(flag_c), 16'(m_c));
        chk(flag_z == m_z, {tag, " flag_z"}, 16'(flag_z), 16'(m_z));
        chk(flag_e == m_e, {tag, " flag_e"}, 16'(flag_e), 16'(m_e));
    endtask

    // Reference model of one instruction (R2..R9); returns whether it issues and its address.
    task automatic m_exec(input logic [12:0] op, output bit iss, output logic [15:0] ea);
        logic [4:0]  s;
        logic [15:0] base;
        iss = (op[12:3] == 10'b1100111100);
        base = op[1] ? m_y : m_x;
        ea = (m_e && !op[0]) ? {op[1] ? 8'hFF : 8'h00, m_imm} : base;
        if (iss) begin
            s = 5'(op[2] ? m_b : m_a) + 5'(mval(ea)) + 5'(m_c);
            if (op[2]) m_b = s[3:0]; else m_a = s[3:0];
            m_c = s[4];
            m_z = (s[3:0] == 0);
            if (op[0]) begin
                if (op[1]) m_y = m_y + 1; else m_x = m_x + 1;
            end
        end
        m_e = 0;
    endtask

    task automatic do_insn(input logic [12:0] op, input string tag);
        bit iss;
        logic [15:0] ea;
        @(negedge clk);
        insn_valid = 1; insn = op;
        #1;
        m_exec(op, iss, ea);
        chk(mem_rd == iss, {tag, " mem_rd"}, 16'(mem_rd), 16'(iss));
        if (iss) chk(mem_addr == ea, {tag, " mem_addr"}, mem_addr, ea);
        @(negedge clk);
        insn_valid = 0;
        @(negedge clk);
        chk_state(tag);
    endtask

    task automatic do_pfx(input logic [7:0] imm);
        @(negedge clk);
        pfx_load = 1; pfx_imm = imm;
        @(negedge clk);
        pfx_load = 0;
        m_e = 1; m_imm = imm;
        chk(flag_e == 1'b1, "R10 prefix sets E", 16'(flag_e), 16'd1);
    endtask

    task automatic burst(input logic [12:0] op, input int n);
        bit iss;
        logic [15:0] ea;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            insn_valid = 1; insn = op;
            m_exec(op, iss, ea);
        end
        @(negedge clk);
        insn_valid = 0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk_state("R1 reset");
        chk(mem_rd == 1'b0, "R1 reset mem_rd", 16'(mem_rd), 16'd0);

        // Sweep all opcodes, with and without prefix (R3..R9)
        for (int rep = 0; rep < 6; rep++) begin
            for (int o = 0; o < 8; o++) begin
                if (rep % 2 == 1) do_pfx(8'(rep * 37 + o * 11));
                do_insn(13'h19E0 + 13'(o), (rep % 2 == 1) ? "R7 R8 R9 prefixed" : "R3 R4 R5 R6 plain");
            end
        end

        // Out-of-family words, each after a prefix (R2, R10)
        do_pfx(8'h5A); do_insn(13'h19E8, "R2 R10 foreign 19E8");
        do_pfx(8'hA5); do_insn(13'h09E0, "R2 R10 foreign 09E0");
        do_pfx(8'h3C); do_insn(13'h19DF, "R2 R10 foreign 19DF");
        do_insn(13'h1FFF, "R2 foreign 1FFF");

        // Prefix and instruction in the same cycle (R10)
        @(negedge clk);
        pfx_load = 1; pfx_imm = 8'h77; insn_valid = 1; insn = 13'h19E0;
        #1;
        chk(mem_rd == 1'b0, "R10 collision no read", 16'(mem_rd), 16'd0);
        @(negedge clk);
        pfx_load = 0; insn_valid = 0;
        m_e = 1; m_imm = 8'h77;
        @(negedge clk);
        chk_state("R10 collision");
        do_insn(13'h19E2, "R8 after collision");

        // Back-to-back bursts with carry chaining (R11)
        burst(13'h19E1, 40);
        chk_state("R11 burst A,X+");
        burst(13'h19E7, 40);
        chk_state("R11 burst B,Y+");
        for (int k = 0; k < 8; k++) begin
            burst(13'h19E0 + 13'(k), 3);
        end
        chk_state("R11 mixed burst");

        // Pointer wrap on X (R6)
        burst(13'h19E1, int'(16'hFFFF - m_x));
        chk(idx_x == 16'hFFFF, "R6 X at top", idx_x, 16'hFFFF);
        chk_state("R6 before wrap");
        do_pfx(8'h12);
        do_insn(13'h19E1, "R6 R9 wrap X");
        chk(idx_x == 16'h0000, "R6 X wrapped", idx_x, 16'h0000);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule